// File: doc/BRIEF.md
# Key-Protected Sequence Table Bank

This block stores the instruction sequences that a flash-command sequencer replays. It holds sixteen sequences of four 32-bit words each. Software reaches the storage through a simple register port with address, write data, write strobe and read data. The sequencer fetches words through a separate read port that it indexes by sequence number and word number.

Table writes take effect only while the bank is unlocked. Changing the lock state takes two writes: a magic key value to the key register, then a command to the lock control register on the very next register write. A single stray write therefore cannot open the bank or rewrite a stored sequence.

To update an entry, software writes the key and then an unlock command. It then writes the four words of the entry, writes the key again and finally sends a lock command.

Top module: `seq_table_bank`

## Requirements
- R1: After reset the bank is unlocked, and every table word reads as zero on both read ports.
- R2: Word w (0..3) of sequence s (0..15) lives at byte address 0x310 + 16*s + 4*w. A write whose address is not a multiple of four, or lies outside 0x310..0x40F, changes no word. A read of any address other than a table word or the lock control register returns zero.
- R3: While the bank is unlocked, a write to a table address stores the write data. The stored word is visible on both read ports from the cycle after the write.
- R4: While the bank is locked, writes to table addresses are dropped. Reads on both ports still return the stored contents.
- R5: Writing 0x5AF05AF0 to the key register at 0x300 arms the key. A write to the lock control register at 0x304 while the key is armed acts on its data: bit 0 set locks the bank, otherwise bit 1 set unlocks it. Lock therefore wins when both bits are set.
- R6: A lock control write made while the key is not armed is ignored, and the lock state does not change.
- R7: An armed key applies only to the next register write. It is disarmed by any other register write, by a key write with a wrong value, and by a lock control write whose data has neither bit set.
- R8: The lock control register reads back 0x1 when the bank is locked and 0x2 when it is unlocked. The key register reads as zero.
- R9: The sequencer port returns the word at index {seq_id, seq_word} combinationally, with no wait on the register port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| seq_id | input | 4 | Sequence number fetched by the sequencer |
| seq_word | input | 2 | Word number within the sequence |
| seq_data | output | 32 | Fetched table word |

## Verification
The table is first filled with a distinct pattern for every word. It is then read back in reverse order on the sequencer port while the register port walks forward, so an address decode that aliases sequences or words shows up as a mismatch on one port or the other.

Lock handling is tried with these patterns:
- a command with no key before it;
- a key followed by an unrelated write;
- a wrong key value;
- a key followed by an empty command;
- a command with both bits set.

Each pattern separates a correct one-shot key from one that is sticky, ignored, or gives the wrong bit priority.

Writes made while locked, writes to unaligned addresses and writes to out-of-range addresses are each followed by readback. This shows that they touched no storage.

// File: rtl/seq_table_bank.sv
module seq_table_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_SEQ = 16,
  parameter int SEQ_WORDS = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'h304,
  parameter logic [ADDR_W-1:0] TBL_BASE = 12'h310,
  parameter logic [DATA_W-1:0] KEY_VALUE = 32'h5AF05AF0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic [$clog2(NUM_SEQ)-1:0]   seq_id,
  input  logic [$clog2(SEQ_WORDS)-1:0] seq_word,
  output logic [DATA_W-1:0]            seq_data
);
  localparam int N_WORDS = NUM_SEQ * SEQ_WORDS;
  localparam int SEQ_W = $clog2(NUM_SEQ);
  localparam int WRD_W = $clog2(SEQ_WORDS);
  localparam int IDX_W = SEQ_W + WRD_W;
  localparam logic [ADDR_W-1:0] TBL_BYTES = ADDR_W'(N_WORDS * 4);

  logic locked;
  logic key_armed;
  logic [N_WORDS-1:0][DATA_W-1:0] words;

  logic [ADDR_W-1:0] tbl_off;
  logic              tbl_hit;
  logic [IDX_W-1:0]  tbl_idx;
  logic              key_wr;
  logic              lock_wr;
  logic              tbl_wr;

  assign tbl_off = reg_addr - TBL_BASE;
  assign tbl_hit = (reg_addr >= TBL_BASE) && (tbl_off < TBL_BYTES) && (reg_addr[1:0] == 2'b00);
  assign tbl_idx = tbl_off[IDX_W+1:2];
  assign key_wr  = reg_we && (reg_addr == KEY_ADDR);
  assign lock_wr = reg_we && (reg_addr == LOCK_ADDR);
  assign tbl_wr  = reg_we && tbl_hit && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_armed <= 1'b0;
      locked    <= 1'b0;
    end else if (reg_we) begin
      key_armed <= key_wr && (reg_wdata == KEY_VALUE);
      if (lock_wr && key_armed) begin
        if (reg_wdata[0])
          locked <= 1'b1;
        else if (reg_wdata[1])
          locked <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (tbl_wr && (tbl_idx == IDX_W'(g)))
        q <= reg_wdata;
    end
    assign words[g] = q;
  end

  assign seq_data = words[{seq_id, seq_word}];

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit)
      reg_rdata = words[tbl_idx];
    else if (reg_addr == LOCK_ADDR)
      reg_rdata = {{(DATA_W-2){1'b0}}, ~locked, locked};
  end
endmodule

// File: rtl/seq_table_bank_chk.sv
module seq_table_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_SEQ = 16,
  parameter int SEQ_WORDS = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'h304,
  parameter logic [ADDR_W-1:0] TBL_BASE = 12'h310,
  parameter logic [DATA_W-1:0] KEY_VALUE = 32'h5AF05AF0
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_we,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [DATA_W-1:0]            reg_wdata,
  input logic [DATA_W-1:0]            reg_rdata,
  input logic [$clog2(NUM_SEQ)-1:0]   seq_id,
  input logic [$clog2(SEQ_WORDS)-1:0] seq_word,
  input logic [DATA_W-1:0]            seq_data,
  input logic                         locked,
  input logic                         key_armed
);
  localparam int IDX_W = $clog2(NUM_SEQ) + $clog2(SEQ_WORDS);
  localparam logic [ADDR_W-1:0] TBL_BYTES = ADDR_W'(NUM_SEQ * SEQ_WORDS * 4);

  logic [ADDR_W-1:0] off;
  logic              hit_sel;

  assign off = reg_addr - TBL_BASE;
  assign hit_sel = reg_we && (reg_addr >= TBL_BASE) && (off < TBL_BYTES) &&
                   (reg_addr[1:0] == 2'b00) && (off[IDX_W+1:2] == {seq_id, seq_word});

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!locked && seq_data == '0)); // R1

  AST_OPEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && hit_sel) |=> (!$stable({seq_id, seq_word}) || seq_data == $past(reg_wdata))); // R3

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && hit_sel) |=> (!$stable({seq_id, seq_word}) || $stable(seq_data))); // R4

  AST_NO_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == LOCK_ADDR && !key_armed) |=> $stable(locked)); // R6

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    key_armed |-> $past(reg_we && reg_addr == KEY_ADDR && reg_wdata == KEY_VALUE)); // R7

  AST_STATE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LOCK_ADDR) |-> ($countones(reg_rdata[1:0]) == 1 && reg_rdata[DATA_W-1:2] == '0)); // R8
endmodule

bind seq_table_bank seq_table_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEQ(NUM_SEQ), .SEQ_WORDS(SEQ_WORDS),
  .KEY_ADDR(KEY_ADDR), .LOCK_ADDR(LOCK_ADDR), .TBL_BASE(TBL_BASE), .KEY_VALUE(KEY_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .seq_id(seq_id), .seq_word(seq_word), .seq_data(seq_data),
  .locked(locked), .key_armed(key_armed)
);

// File: tb/sim_seq_table_bank.sv
module sim_seq_table_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  seq_id = '0;
  logic [1:0]  seq_word = '0;
  logic [31:0] seq_data;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mem [64];
  bit m_locked = 0;
  bit m_armed = 0;

  localparam int KEY = 'h300;
  localparam int LCK = 'h304;
  localparam int BASE = 'h310;
  localparam logic [31:0] KEYV = 32'h5AF05AF0;

  always #5 clk = ~clk;

  seq_table_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .seq_id(seq_id), .seq_word(seq_word), .seq_data(seq_data)
  );

  function automatic bit is_tbl(int a);
    return a >= BASE && a < BASE + 256 && (a % 4) == 0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (is_tbl(a)) return mem[(a - BASE) / 4];
    if (a == LCK) return m_locked ? 32'h1 : 32'h2;
    return 32'h0;
  endfunction

  task automatic m_write(int a, logic [31:0] d);
    if (a == KEY) m_armed = (d == KEYV);
    else if (a == LCK) begin
      if (m_armed) begin
        if (d[0]) m_locked = 1;
        else if (d[1]) m_locked = 0;
      end
      m_armed = 0;
    end else begin
      m_armed = 0;
      if (!m_locked && is_tbl(a)) mem[(a - BASE) / 4] = d;
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, int a, logic [31:0] d, int sid, int sw, string tag);
    reg_we = we; reg_addr = a[11:0]; reg_wdata = d;
    seq_id = sid[3:0]; seq_word = sw[1:0];
    #1;
    check(tag, "reg_rdata", reg_rdata, m_read(a));
    check(tag, "seq_data", seq_data, mem[sid * 4 + sw]);
    @(posedge clk);
    if (we) m_write(a, d);
    @(negedge clk);
  endtask

  task automatic rd(int a, string tag);
    step(0, a, 32'h0, 0, 0, tag);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    step(1, a, d, 0, 0, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R8 reset state
    rd(LCK, "R1");
    rd(KEY, "R8");
    rd(BASE, "R1");
    step(0, BASE + 'hFC, 0, 15, 3, "R1");
    // R3 R2 fill every word with a distinct pattern
    for (int i = 0; i < 64; i++)
      step(1, BASE + 4 * i, 32'hA5000000 ^ (i * 32'h01030507), i / 4, i % 4, "R3");
    // R9 R2 reverse walk on the sequencer port
    for (int i = 0; i < 64; i++)
      step(0, BASE + 4 * i, 0, (63 - i) / 4, (63 - i) % 4, "R9");
    // R2 unaligned and out-of-range writes are ignored
    wr(BASE + 1, 32'hDEADBEEF, "R2");
    wr(BASE + 'h100, 32'hCAFEF00D, "R2");
    wr(BASE - 4, 32'h12345678, "R2");
    rd(BASE, "R2");
    rd(BASE + 'h100, "R2");
    rd(BASE - 4, "R2");
    rd(BASE + 'h24, "R2");
    // R6 lock command without key
    wr(LCK, 32'h1, "R6");
    rd(LCK, "R6");
    wr(BASE + 8, 32'h0BADF00D, "R6");
    step(0, BASE + 8, 0, 0, 2, "R6");
    // R5 key then lock
    wr(KEY, KEYV, "R5");
    wr(LCK, 32'h1, "R5");
    rd(LCK, "R5");
    // R4 locked writes dropped, reads still work
    step(1, BASE + 'h40, 32'h11111111, 4, 0, "R4");
    step(0, BASE + 'h40, 0, 4, 0, "R4");
    wr(BASE + 'hFC, 32'h22222222, "R4");
    step(0, BASE + 'hFC, 0, 15, 3, "R4");
    // R6 unlock without key
    wr(LCK, 32'h2, "R6");
    rd(LCK, "R6");
    // R7 key followed by another write
    wr(KEY, KEYV, "R7");
    wr(BASE, 32'h33333333, "R7");
    wr(LCK, 32'h2, "R7");
    rd(LCK, "R7");
    // R7 wrong key
    wr(KEY, 32'h5AF05AF1, "R7");
    wr(LCK, 32'h2, "R7");
    rd(LCK, "R7");
    // R7 key, then another key write with a wrong value
    wr(KEY, KEYV, "R7");
    wr(KEY, 32'h0, "R7");
    wr(LCK, 32'h2, "R7");
    rd(LCK, "R7");
    // R5 correct unlock
    wr(KEY, KEYV, "R5");
    wr(LCK, 32'h2, "R5");
    rd(LCK, "R5");
    // R7 empty command consumes the key
    wr(KEY, KEYV, "R7");
    wr(LCK, 32'h0, "R7");
    wr(LCK, 32'h1, "R7");
    rd(LCK, "R7");
    // R5 both bits set: lock wins
    wr(KEY, KEYV, "R5");
    wr(LCK, 32'h3, "R5");
    rd(LCK, "R5");
    // R3 R5 full entry update sequence
    wr(KEY, KEYV, "R5");
    wr(LCK, 32'h2, "R5");
    for (int w = 0; w < 4; w++)
      step(1, BASE + 'h70 + 4 * w, 32'hC0DE0000 + w, 7, w, "R3");
    wr(KEY, KEYV, "R5");
    wr(LCK, 32'h1, "R5");
    for (int w = 0; w < 4; w++)
      step(0, BASE + 'h70 + 4 * w, 0, 7, w, "R9");
    rd(LCK, "R8");
    rd(KEY, "R8");
    done = 1;
    summary();
    $finish;
  end
endmodule